// File: doc/BRIEF.md
# SDRAM Command Sequencer with Programmable Timing

This block turns single and burst access requests into the command stream that a single-data-rate SDRAM expects. It keeps one open row per bank. An access to a closed bank opens the row first. An access to an open bank with a different row closes the bank, opens the new row and then reads or writes. An access that hits the open row goes straight to the column command. The wait after every command comes from fields that software loads, counted in bus clocks. Single and burst transfers have separate turnaround fields, and the field chosen depends on what the next command is.

Software can also inject commands through the control register: a precharge of every bank, an auto refresh, and a load-mode command that carries the stored mode code as its address. A device is brought up this way, one register write per step. A refresh request input is served between accesses. The block sends a precharge of all banks, then a refresh, and acknowledges the request. A read also opens a capture window that starts a programmed CAS latency after the command. The data-bus drive enable stays low while read data is owed.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cmdOut is NOP, ackOut, refAck and capture are 0, and dataDrive is 1.
- R2: The command codes are NOP=0, PRE=1, ACT=2, RD=3, WR=4, REF=5, LMR=6. The muxSel codes are 0 none, 1 row, 2 column, 3 mode code. An access to a bank with no open row issues ACT (muxSel row) and then RD or WR (muxSel column). ackOut pulses in the cycle of that RD or WR. cmdBank carries reqBank.
- R3: An access whose bank already has its row open issues only the RD or WR.
- R4: An access whose bank has a different row open issues PRE for that bank with preAll low, then ACT, then RD or WR.
- R5: After a command, the next one issues in the first cycle that is at least the gap after it, and never earlier. The single timing register (address 2) holds the gaps in 4-bit fields from bit 0 upward: read to any command, write to any command, CAS latency, ACT to RD/WR, PRE to any command, REF to any command. After LMR the gap is 2.
- R6: The burst timing register (address 3) holds, from bit 0 upward: burst read to anything but a write, burst write to any command, burst read to write, and burst length minus one. A burst is selected by reqBurst.
- R7: capture is high for 1 cycle (single) or length cycles (burst), starting CAS-latency cycles after the RD.
- R8: dataDrive is low from the RD cycle through the last capture cycle and high otherwise.
- R9: A write to the control register (address 1) with bit 1 set issues one PRE with preAll high. A write with bit 2 set issues one REF. PRE with preAll closes every open row.
- R10: A write to the mode register (address 0) with bit 16 set issues one LMR (muxSel mode) only while control bit 23 is set. The write then stores bits 13:0 as lmrCode. extMode is high when lmrCode[13:12] is 01. A write while bit 23 is clear is ignored and leaves lmrCode unchanged.
- R11: While refPend is high and no access is in progress, the block issues PRE with preAll high, then REF with refAck high. The next ACT waits the refresh gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 mode, 1 control, 2 single timing, 3 burst timing |
| regData | input | REG_W | Register write data |
| reqValid | input | 1 | Access request, held until ackOut |
| reqWrite | input | 1 | 1 write, 0 read |
| reqBurst | input | 1 | 1 burst, 0 single |
| reqBank | input | BANK_W | Bank of the access |
| reqRow | input | ROW_W | Row of the access |
| ackOut | output | 1 | Pulses with the access's RD or WR |
| refPend | input | 1 | Refresh wanted, held until refAck |
| refAck | output | 1 | Pulses with the REF that serves refPend |
| cmdOut | output | 3 | SDRAM command code |
| cmdBank | output | BANK_W | Bank for PRE, ACT, RD, WR |
| muxSel | output | 2 | Address multiplexer phase |
| preAll | output | 1 | Precharge-all flag |
| lmrCode | output | MODE_W | Stored mode code for LMR |
| extMode | output | 1 | LMR targets the extended mode register |
| capture | output | 1 | Read-data capture strobe |
| dataDrive | output | 1 | Data bus drive enable |

## Verification
The assertions assume that the CAS-latency field is 2 or 3. They also assume that reads are spaced so that one capture window ends before the next one opens. The bench programs gaps that keep each read window separate. The assertions and the bench both take request and refresh inputs as held stable until their acknowledge and dropped in the cycle after it. The bench starts a new access or register write only after the previous one is fully served.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_PRE = 3'd1, CMD_ACT = 3'd2, CMD_RD = 3'd3,
    CMD_WR  = 3'd4, CMD_REF = 3'd5, CMD_LMR = 3'd6
  } sdCmd_e;

  typedef enum logic [1:0] {
    MUX_NONE = 2'd0, MUX_ROW = 2'd1, MUX_COL = 2'd2, MUX_MODE = 2'd3
  } muxSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    sdCmd_e cmd;
    logic   allBanks;
    logic   clrSwPre;
    logic   clrSwRef;
    logic   clrSwLmr;
  } seqStrb_t;
endpackage

// File: rtl/sdram_seq_dp.sv
`timescale 1ns/1ps
module sdram_seq_dp import sdram_seq_pkg::*; #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int MODE_W = 14,
  parameter int FLD_W  = 4,
  parameter int REG_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regData,
  input  logic              reqBurst,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  seqStrb_t          strb,
  output logic              gapOk,
  output logic              gapWrOk,
  output logic              bankOpen,
  output logic              rowHit,
  output logic              swPre,
  output logic              swRef,
  output logic              swLmr,
  output logic              capture,
  output logic              dataDrive,
  output logic [MODE_W-1:0] lmrCode,
  output logic              extMode
);
  localparam int BANKS   = 1 << BANK_W;
  localparam int CNT_W   = FLD_W + 1;
  localparam int SGL_W   = 6 * FLD_W;
  localparam int BST_W   = 4 * FLD_W;
  localparam int STB_BIT = 16;
  localparam logic [CNT_W-1:0] SINCE_MAX = '1;
  localparam logic [FLD_W-1:0] MODE_GAP  = FLD_W'(2);
  localparam logic [SGL_W-1:0] SGL_RST = {FLD_W'(6), FLD_W'(2), FLD_W'(2),
                                          FLD_W'(2), FLD_W'(2), FLD_W'(12)};
  localparam logic [BST_W-1:0] BST_RST = {FLD_W'(7), FLD_W'(11), FLD_W'(8), FLD_W'(8)};

  logic [SGL_W-1:0] sglReg;
  logic [BST_W-1:0] bstReg;
  logic             unlock;

  wire [FLD_W-1:0] rdGap  = sglReg[0*FLD_W +: FLD_W];
  wire [FLD_W-1:0] wrGap  = sglReg[1*FLD_W +: FLD_W];
  wire [FLD_W-1:0] casLat = sglReg[2*FLD_W +: FLD_W];
  wire [FLD_W-1:0] actGap = sglReg[3*FLD_W +: FLD_W];
  wire [FLD_W-1:0] preGap = sglReg[4*FLD_W +: FLD_W];
  wire [FLD_W-1:0] refGap = sglReg[5*FLD_W +: FLD_W];
  wire [FLD_W-1:0] bRdGap = bstReg[0*FLD_W +: FLD_W];
  wire [FLD_W-1:0] bWrGap = bstReg[1*FLD_W +: FLD_W];
  wire [FLD_W-1:0] bRdWr  = bstReg[2*FLD_W +: FLD_W];
  wire [FLD_W-1:0] lenM1  = bstReg[3*FLD_W +: FLD_W];

  wire ctlWr  = regWe && (regAddr == 2'd1);
  wire modeWr = regWe && (regAddr == 2'd0) && unlock;

  // Registers and software command requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sglReg <= SGL_RST; bstReg <= BST_RST; unlock <= 1'b0; lmrCode <= '0;
      swPre <= 1'b0; swRef <= 1'b0; swLmr <= 1'b0;
    end else begin
      if (regWe && regAddr == 2'd2) sglReg <= regData[SGL_W-1:0];
      if (regWe && regAddr == 2'd3) bstReg <= regData[BST_W-1:0];
      if (ctlWr) unlock <= regData[REG_W-1];
      if (modeWr) lmrCode <= regData[MODE_W-1:0];
      swPre <= (swPre && !strb.clrSwPre) || (ctlWr && regData[1]);
      swRef <= (swRef && !strb.clrSwRef) || (ctlWr && regData[2]);
      swLmr <= (swLmr && !strb.clrSwLmr) || (modeWr && regData[STB_BIT]);
    end
  end
  assign extMode = (lmrCode[MODE_W-1 -: 2] == 2'b01);

  // Open-row table
  logic [BANKS-1:0] openV;
  logic [ROW_W-1:0] openRow [BANKS];
  logic [BANKS-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) openV <= '0;
    else if (strb.cmd == CMD_PRE) begin
      if (strb.allBanks) openV <= '0;
      else openV[reqBank] <= 1'b0;
    end else if (strb.cmd == CMD_ACT) openV[reqBank] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.cmd == CMD_ACT) openRow[reqBank] <= reqRow;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_hit
    assign hitVec[b] = openV[b] && (openRow[b] == reqRow);
  end
  assign bankOpen = openV[reqBank];
  assign rowHit   = hitVec[reqBank];

  // Command spacing
  logic [CNT_W-1:0] since;
  logic [FLD_W-1:0] gapGen, gapWr, nGen, nWr;

  always_comb begin
    nGen = '0; nWr = '0;
    unique case (strb.cmd)
      CMD_PRE: begin nGen = preGap;   nWr = preGap;   end
      CMD_ACT: begin nGen = actGap;   nWr = actGap;   end
      CMD_REF: begin nGen = refGap;   nWr = refGap;   end
      CMD_LMR: begin nGen = MODE_GAP; nWr = MODE_GAP; end
      CMD_RD:  begin nGen = reqBurst ? bRdGap : rdGap; nWr = reqBurst ? bRdWr : rdGap; end
      CMD_WR:  begin nGen = reqBurst ? bWrGap : wrGap; nWr = nGen; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      since <= SINCE_MAX; gapGen <= '0; gapWr <= '0;
    end else if (strb.cmd != CMD_NOP) begin
      since <= CNT_W'(1); gapGen <= nGen; gapWr <= nWr;
    end else if (since != SINCE_MAX) since <= since + 1'b1;
  end
  assign gapOk   = since >= {1'b0, gapGen};
  assign gapWrOk = since >= {1'b0, gapWr};

  // Read capture window
  logic [FLD_W-1:0] capWait;
  logic [FLD_W:0]   capLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWait <= '0; capLeft <= '0;
    end else if (strb.cmd == CMD_RD) begin
      capWait <= casLat - 1'b1;
      capLeft <= reqBurst ? {1'b0, lenM1} + 1'b1 : (FLD_W+1)'(1);
    end else if (capWait != '0) capWait <= capWait - 1'b1;
    else if (capLeft != '0) capLeft <= capLeft - 1'b1;
  end
  assign capture   = (capWait == '0) && (capLeft != '0);
  assign dataDrive = !((strb.cmd == CMD_RD) || (capLeft != '0));
endmodule

// File: rtl/sdram_seq_ctl.sv
`timescale 1ns/1ps
module sdram_seq_ctl import sdram_seq_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     refPend,
  input  logic     gapOk,
  input  logic     gapWrOk,
  input  logic     bankOpen,
  input  logic     rowHit,
  input  logic     swPre,
  input  logic     swRef,
  input  logic     swLmr,
  output seqStrb_t strb,
  output muxSel_e  muxSel,
  output logic     ackOut,
  output logic     refAck
);
  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_ACT, ST_RW, ST_REF} st_e;
  st_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else st <= nxt;
  end

  always_comb begin
    strb = '0; nxt = st; muxSel = MUX_NONE; ackOut = 1'b0; refAck = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (swPre || swRef || swLmr || refPend) begin
          if (gapOk) begin
            if (swPre) begin
              strb.cmd = CMD_PRE; strb.allBanks = 1'b1; strb.clrSwPre = 1'b1;
            end else if (swRef) begin
              strb.cmd = CMD_REF; strb.clrSwRef = 1'b1;
            end else if (swLmr) begin
              strb.cmd = CMD_LMR; strb.clrSwLmr = 1'b1; muxSel = MUX_MODE;
            end else begin
              strb.cmd = CMD_PRE; strb.allBanks = 1'b1; nxt = ST_REF;
            end
          end
        end else if (reqValid) begin
          nxt = rowHit ? ST_RW : (bankOpen ? ST_PRE : ST_ACT);
        end
      end
      ST_PRE: if (gapOk) begin strb.cmd = CMD_PRE; nxt = ST_ACT; end
      ST_ACT: if (gapOk) begin strb.cmd = CMD_ACT; muxSel = MUX_ROW; nxt = ST_RW; end
      ST_RW: if (reqWrite ? gapWrOk : gapOk) begin
        strb.cmd = reqWrite ? CMD_WR : CMD_RD; muxSel = MUX_COL; ackOut = 1'b1; nxt = ST_IDLE;
      end
      ST_REF: if (gapOk) begin strb.cmd = CMD_REF; refAck = 1'b1; nxt = ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq import sdram_seq_pkg::*; #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int MODE_W = 14,
  parameter int FLD_W  = 4,
  parameter int REG_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  output logic              ackOut,
  input  logic              refPend,
  output logic              refAck,
  output logic [2:0]        cmdOut,
  output logic [BANK_W-1:0] cmdBank,
  output logic [1:0]        muxSel,
  output logic              preAll,
  output logic [MODE_W-1:0] lmrCode,
  output logic              extMode,
  output logic              capture,
  output logic              dataDrive
);
  seqStrb_t strb;
  muxSel_e  muxSelE;
  logic gapOk, gapWrOk, bankOpen, rowHit, swPre, swRef, swLmr;

  sdram_seq_ctl ctl_i (
    .clk, .rstN, .reqValid, .reqWrite, .refPend, .gapOk, .gapWrOk,
    .bankOpen, .rowHit, .swPre, .swRef, .swLmr,
    .strb, .muxSel(muxSelE), .ackOut, .refAck
  );

  sdram_seq_dp #(.BANK_W(BANK_W), .ROW_W(ROW_W), .MODE_W(MODE_W),
                 .FLD_W(FLD_W), .REG_W(REG_W)) dp_i (
    .clk, .rstN, .regWe, .regAddr, .regData, .reqBurst, .reqBank, .reqRow,
    .strb, .gapOk, .gapWrOk, .bankOpen, .rowHit, .swPre, .swRef, .swLmr,
    .capture, .dataDrive, .lmrCode, .extMode
  );

  assign cmdOut  = strb.cmd;
  assign cmdBank = reqBank;
  assign muxSel  = muxSelE;
  assign preAll  = (strb.cmd == CMD_PRE) && strb.allBanks;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk import sdram_seq_pkg::*; (
  input logic       clk,
  input logic       rstN,
  input logic       ackOut,
  input logic       refAck,
  input logic [2:0] cmdOut,
  input logic [1:0] muxSel,
  input logic       preAll,
  input logic       capture,
  input logic       dataDrive
);
  // R2: acknowledge only with a column command
  a_r2_ack_with_col: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> ((cmdOut == CMD_RD) || (cmdOut == CMD_WR)) && (muxSel == MUX_COL));

  // R8: bus released whenever read data is captured
  a_r8_no_drive_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> !dataDrive);

  // R11: refresh acknowledge only with REF
  a_r11_refack_is_ref: assert property (@(posedge clk) disable iff (!rstN)
    refAck |-> (cmdOut == CMD_REF) && !ackOut);

  // R9: precharge-all flag only on PRE
  a_r9_preall_on_pre: assert property (@(posedge clk) disable iff (!rstN)
    preAll |-> (cmdOut == CMD_PRE));

  // R7: a capture window opens two or three cycles after a read
  a_r7_capture_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capture) |-> ($past(cmdOut, 2) == CMD_RD) || ($past(cmdOut, 3) == CMD_RD));

  // R1: quiet outputs in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    (rstN && !$past(rstN)) |-> (cmdOut == CMD_NOP) && dataDrive && !capture);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .ackOut(ackOut), .refAck(refAck), .cmdOut(cmdOut),
  .muxSel(muxSel), .preAll(preAll), .capture(capture), .dataDrive(dataDrive)
);

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;
  import sdram_seq_pkg::*;
  localparam int BANK_W = 2, ROW_W = 13, MODE_W = 14, REG_W = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, regWe = 1'b0, reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0, refPend = 1'b0;
  logic [1:0] regAddr = '0;
  logic [REG_W-1:0] regData = '0;
  logic [BANK_W-1:0] reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic ackOut, refAck, preAll, extMode, capture, dataDrive;
  logic [2:0] cmdOut;
  logic [BANK_W-1:0] cmdBank;
  logic [1:0] muxSel;
  logic [MODE_W-1:0] lmrCode;

  sdram_cmd_seq dut_i (.*);

  typedef struct {
    sdCmd_e cmd; int bank; muxSel_e mux; bit all; int code; bit ext;
    bit isRef; int earliest; bit chained; bit burst; string tag;
  } exp_t;
  exp_t q[$];

  int cyc = 0, errs = 0, checks = 0;
  bit done = 0, mUnlock = 0;
  int rdG = 12, wrG = 2, cl = 2, a2rw = 2, p2a = 2, r2a = 6, bRd = 8, bWr = 8, bRdWr = 11, blen = 8;
  int gapG = 0, gapW = 0, lastCyc = -1000;
  bit lastBurst = 0;
  bit mOpen[4];
  int mRow[4];
  bit expCap[int];
  bit expLow[int];
  string curTag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Reference model, compared every clock
  always @(negedge clk) begin
    exp_t e; int g, expC, len; string gt; sdCmd_e c;
    if (rstN && !done) begin
      c = sdCmd_e'(cmdOut);
      if (c != CMD_NOP) begin
        if (q.size() == 0) chk(0, curTag, "unexpected command", int'(c), 0);
        else begin
          e = q.pop_front();
          g = (c == CMD_WR) ? gapW : gapG;
          if (g < 1) g = 1;
          expC = lastCyc + g;
          if (!e.chained && e.earliest > expC) expC = e.earliest;
          gt = lastBurst ? "R6" : "R5";
          chk(c == e.cmd, e.tag, "command", int'(c), int'(e.cmd));
          chk(cyc == expC, gt, "issue cycle", cyc, expC);
          chk(muxSel == e.mux, e.tag, "muxSel", muxSel, int'(e.mux));
          chk(preAll == e.all, e.tag, "preAll", preAll, e.all);
          if (e.cmd inside {CMD_ACT, CMD_RD, CMD_WR} || (e.cmd == CMD_PRE && !e.all))
            chk(cmdBank == e.bank, e.tag, "cmdBank", cmdBank, e.bank);
          if (e.cmd == CMD_LMR) begin
            chk(lmrCode == e.code, "R10", "lmrCode", lmrCode, e.code);
            chk(extMode == e.ext, "R10", "extMode", extMode, e.ext);
          end
          chk(ackOut == (e.cmd inside {CMD_RD, CMD_WR}), "R2", "ackOut", ackOut, 1);
          chk(refAck == e.isRef, "R11", "refAck", refAck, e.isRef);
          if (c == CMD_RD) begin
            len = e.burst ? blen : 1;
            for (int k = 0; k < len; k++) expCap[cyc + cl + k] = 1;
            for (int k = 0; k < cl + len; k++) expLow[cyc + k] = 1;
          end
          case (c)
            CMD_PRE: begin gapG = p2a; gapW = p2a; end
            CMD_ACT: begin gapG = a2rw; gapW = a2rw; end
            CMD_REF: begin gapG = r2a; gapW = r2a; end
            CMD_LMR: begin gapG = 2; gapW = 2; end
            CMD_RD:  begin gapG = e.burst ? bRd : rdG; gapW = e.burst ? bRdWr : rdG; end
            CMD_WR:  begin gapG = e.burst ? bWr : wrG; gapW = gapG; end
            default: ;
          endcase
          lastBurst = (c inside {CMD_RD, CMD_WR}) && e.burst;
          lastCyc = cyc;
        end
      end else begin
        chk(!ackOut, "R2", "ackOut idle", ackOut, 0);
        chk(!refAck, "R11", "refAck idle", refAck, 0);
      end
      chk(capture == expCap.exists(cyc), "R7", "capture", capture, expCap.exists(cyc));
      chk(dataDrive == !expLow.exists(cyc), "R8", "dataDrive", dataDrive, !expLow.exists(cyc));
    end
  end

  function automatic exp_t mk(sdCmd_e c, int bank, muxSel_e m, bit all, int earliest,
                              bit chained, bit burst, string tag);
    exp_t e;
    e.cmd = c; e.bank = bank; e.mux = m; e.all = all; e.code = 0; e.ext = 0; e.isRef = 0;
    e.earliest = earliest; e.chained = chained; e.burst = burst; e.tag = tag;
    return e;
  endfunction

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(int a, logic [REG_W-1:0] d);
    exp_t e; int w;
    @(posedge clk); #1;
    regWe = 1; regAddr = a[1:0]; regData = d; w = cyc;
    if (a == 1) begin
      curTag = "R9";
      if (d[1]) begin
        q.push_back(mk(CMD_PRE, 0, MUX_NONE, 1, w + 1, 0, 0, "R9"));
        for (int b = 0; b < 4; b++) mOpen[b] = 0;
      end
      if (d[2]) q.push_back(mk(CMD_REF, 0, MUX_NONE, 0, w + 1, 0, 0, "R9"));
      mUnlock = d[23];
    end else if (a == 0) begin
      curTag = "R10";
      if (mUnlock && d[16]) begin
        e = mk(CMD_LMR, 0, MUX_MODE, 0, w + 1, 0, 0, "R10");
        e.code = int'(d[13:0]); e.ext = (d[13:12] == 2'b01);
        q.push_back(e);
      end
    end else if (a == 2) begin
      rdG = d[3:0]; wrG = d[7:4]; cl = d[11:8]; a2rw = d[15:12]; p2a = d[19:16]; r2a = d[23:20];
    end else begin
      bRd = d[3:0]; bWr = d[7:4]; bRdWr = d[11:8]; blen = d[15:12] + 1;
    end
    @(posedge clk); #1;
    regWe = 0;
    drain();
  endtask

  task automatic access(int bank, int row, bit wr, bit burst);
    int r; sdCmd_e rw; string t;
    @(posedge clk); #1;
    reqValid = 1; reqBank = bank[BANK_W-1:0]; reqRow = row[ROW_W-1:0];
    reqWrite = wr; reqBurst = burst; r = cyc;
    rw = wr ? CMD_WR : CMD_RD;
    if (mOpen[bank] && mRow[bank] == row) begin
      t = "R3";
      q.push_back(mk(rw, bank, MUX_COL, 0, r + 1, 0, burst, t));
    end else if (mOpen[bank]) begin
      t = "R4";
      q.push_back(mk(CMD_PRE, bank, MUX_NONE, 0, r + 1, 0, burst, t));
      q.push_back(mk(CMD_ACT, bank, MUX_ROW, 0, 0, 1, burst, t));
      q.push_back(mk(rw, bank, MUX_COL, 0, 0, 1, burst, t));
    end else begin
      t = "R2";
      q.push_back(mk(CMD_ACT, bank, MUX_ROW, 0, r + 1, 0, burst, t));
      q.push_back(mk(rw, bank, MUX_COL, 0, 0, 1, burst, t));
    end
    curTag = t;
    mOpen[bank] = 1; mRow[bank] = row;
    forever begin @(negedge clk); if (ackOut) break; end
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic refresh();
    int p; exp_t e;
    @(posedge clk); #1;
    refPend = 1; p = cyc; curTag = "R11";
    q.push_back(mk(CMD_PRE, 0, MUX_NONE, 1, p, 0, 0, "R11"));
    e = mk(CMD_REF, 0, MUX_NONE, 0, 0, 1, 0, "R11"); e.isRef = 1;
    q.push_back(e);
    for (int b = 0; b < 4; b++) mOpen[b] = 0;
    forever begin @(negedge clk); if (refAck) break; end
    @(posedge clk); #1;
    refPend = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 50000);
      summary();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(cmdOut == 0 && !ackOut && !refAck && !capture && dataDrive, "R1", "outputs in reset", cmdOut, 0);
    end
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    chk(cmdOut == 0 && !capture && dataDrive && !ackOut, "R1", "outputs after reset", cmdOut, 0);

    // R5 / R6: timing fields
    wr_reg(2, 24'h623235);
    wr_reg(3, 24'h007B89);
    // R9: software precharge-all and refresh
    wr_reg(1, 24'h800002);
    wr_reg(1, 24'h800004);
    // R10: extended and base mode loads, then locked write ignored
    wr_reg(0, 24'h011000);
    wr_reg(0, 24'h010023);
    wr_reg(1, 24'h000000);
    wr_reg(0, 24'h010155);
    repeat (12) @(negedge clk);
    chk(lmrCode == 14'h0023, "R10", "lmrCode after locked write", lmrCode, 14'h23);
    chk(q.size() == 0, "R10", "no command from locked write", q.size(), 0);

    access(0, 5, 0, 0);   // R2 closed bank read
    access(0, 5, 1, 0);   // R3 hit write
    access(0, 9, 0, 1);   // R4 miss, burst read
    access(1, 3, 1, 1);   // R2 burst write
    access(1, 3, 0, 0);   // R3 after burst write
    access(1, 3, 1, 0);   // R5 read to write
    refresh();            // R11
    access(1, 3, 0, 0);   // R11 refresh gap before ACT
    drain();
    wr_reg(2, 24'h623335); // CAS latency 3
    access(2, 7, 0, 1);   // R7 burst capture with latency 3
    access(2, 7, 1, 0);   // R6 burst read to write
    access(2, 7, 0, 0);
    drain();
    wr_reg(1, 24'h800002); // R9 closes rows
    access(2, 7, 0, 0);   // reopens with ACT
    drain();
    repeat (20) @(negedge clk);
    done = 1;
    summary();
  end
endmodule